// File: doc/BRIEF.md
# Configurable GPIO Port Slice with Alternate Functions

This block is one eight-pin general-purpose I/O port of a microcontroller. Software reaches four registers through a small register interface: a data latch, a per-pin direction mask, a per-pin pull-up mask and a per-pin alternate-function mask. From these, the block drives an output value, an output enable and a pull-up enable toward each pad. It also returns the pad levels, synchronized through two flops, both to software and to the on-chip peripherals.

Setting a pin's alternate-function bit gives that pin to a peripheral. The peripheral then supplies the pin's output value and output enable, and the direction bit has no effect on that pin. A global external-access strap, active low, forces a fixed group of pins (the external address pins) into alternate mode whatever the alternate-function mask holds. While both that strap and the chip reset are low, a fixed group of strobe pins is pulled up. All three reset sources return every pin to an undriven input: the asynchronous reset pin, a break reset and an opcode-trap reset.

Top module: `gpio_port_slice`

## Requirements
- R1: While `rst_n` is low, every `pad_oe` bit is 0, and the data, direction, pull-up and alternate registers read 0 once `rst_n` has gone low.
- R2: A high `brk_rst` or `trap_rst` at a clock edge clears all four registers at that edge, and takes priority over a register write in the same cycle.
- R3: A pin that is not in alternate mode has `pad_oe` equal to its direction bit (1 = output) and `pad_out` equal to its data latch bit.
- R4: A pin in alternate mode takes `pad_oe` from `alt_oe` and `pad_out` from `alt_out`, whatever its direction bit holds.
- R5: While `ext_mode_n` is 0, the pins in `FORCE_MASK` (default 0x0F) are in alternate mode whatever the alternate register holds.
- R6: `pad_pu` follows the pull-up register. Pull-up bits outside `PULL_MASK` (default 0x7F) cannot be written and always read 0.
- R7: While `ext_mode_n` and `rst_n` are both 0, the pins in `STROBE_MASK` (default 0x30) have `pad_pu` set.
- R8: `alt_in` equals `pad_in` as sampled two rising edges earlier. Both synchronizer stages are 0 after `rst_n`.
- R9: A read of address 0 returns the data latch bit for pins that are normal outputs, and the synchronized pad level for every other pin.
- R10: A write to the data latch takes effect while a pin is an input or in alternate mode. The written value reaches `pad_out` as soon as the pin becomes a normal output.
- R11: Register addresses are 0 data, 1 direction, 2 pull-up and 3 alternate. A write with `reg_we` high lands at the rising edge, and `reg_rdata` reflects `reg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| brk_rst | input | 1 | Synchronous break reset |
| trap_rst | input | 1 | Synchronous opcode-trap reset |
| ext_mode_n | input | 1 | External-access strap, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| alt_out | input | 8 | Peripheral output values |
| alt_oe | input | 8 | Peripheral output enables |
| alt_in | output | 8 | Synchronized pad levels to peripherals |
| pad_in | input | 8 | Raw pad levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |

## Verification
A corrupted direction, pull-up or alternate bit shows on `pad_oe`, `pad_out` or `pad_pu` in the same cycle, because those outputs are combinational from the registers. A wrong synchronizer stage shows on `alt_in` and in data reads two edges after the pad changes. A lost or stale data latch stays hidden while the pin is an input. It appears only when the pin becomes a normal output, so the stimulus writes the latch in input and alternate mode and later switches the pin to output. A reference model is compared against every output on every cycle, across reset, forced-alternate mode, break and trap resets, and random register traffic.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PULL = 2'd2,
        SEL_ALT  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.stg[STAGES-1];

    // The first stage follows the pad one edge later.
    assert_first_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> st_q.stg[0] == $past(din));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] PULL_MASK = 8'h7F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] pull_q,
    output logic [WIDTH-1:0] alt_q
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] pull;
        logic [WIDTH-1:0] alt;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_clr) begin
            st_d = '0;
        end else if (we) begin
            unique case (reg_sel_e'(addr))
                SEL_DATA: st_d.data = wdata;
                SEL_DIR:  st_d.dir  = wdata;
                SEL_PULL: st_d.pull = wdata & PULL_MASK;
                SEL_ALT:  st_d.alt  = wdata;
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_q = st_q.data;
    assign dir_q  = st_q.dir;
    assign pull_q = st_q.pull;
    assign alt_q  = st_q.alt;

    assert_soft_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (data_q == '0 && dir_q == '0 && pull_q == '0 && alt_q == '0));

    assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_clr && !(we && addr == 2'd0)) |=> $stable(data_q));

    assert_pull_only_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_q & ~PULL_MASK) == '0);
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int               WIDTH       = 8,
    parameter logic [WIDTH-1:0] FORCE_MASK  = 8'h0F,
    parameter logic [WIDTH-1:0] STROBE_MASK = 8'h30
) (
    input  logic             rst_n,
    input  logic             ext_mode_n,
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pull_q,
    input  logic [WIDTH-1:0] alt_q,
    input  logic [WIDTH-1:0] alt_out,
    input  logic [WIDTH-1:0] alt_oe,
    input  logic [WIDTH-1:0] sync_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu,
    output logic [WIDTH-1:0] port_view
);
    logic [WIDTH-1:0] alt_eff;
    logic             strobe_hold;

    assign strobe_hold = !ext_mode_n && !rst_n;

    for (genvar b = 0; b < WIDTH; b++) begin : g_pin
        always_comb begin
            alt_eff[b]   = alt_q[b] | (FORCE_MASK[b] & !ext_mode_n);
            pad_out[b]   = alt_eff[b] ? alt_out[b] : data_q[b];
            pad_oe[b]    = rst_n && (alt_eff[b] ? alt_oe[b] : dir_q[b]);
            pad_pu[b]    = pull_q[b] | (STROBE_MASK[b] & strobe_hold);
            port_view[b] = (dir_q[b] && !alt_eff[b]) ? data_q[b] : sync_in[b];
        end
    end

    always_comb begin
        if (!rst_n) begin
            assert_reset_undriven_R1: assert (pad_oe == '0);
        end
    end
endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice
    import gpio_port_pkg::*;
#(
    parameter int               WIDTH       = 8,
    parameter int               SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] PULL_MASK   = 8'h7F,
    parameter logic [WIDTH-1:0] FORCE_MASK  = 8'h0F,
    parameter logic [WIDTH-1:0] STROBE_MASK = 8'h30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             brk_rst,
    input  logic             trap_rst,
    input  logic             ext_mode_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata,
    input  logic [WIDTH-1:0] alt_out,
    input  logic [WIDTH-1:0] alt_oe,
    output logic [WIDTH-1:0] alt_in,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);
    logic [WIDTH-1:0] data_q, dir_q, pull_q, alt_q, sync_q, view;
    logic             soft_clr;

    assign soft_clr = brk_rst | trap_rst;

    gpio_regs #(.WIDTH(WIDTH), .PULL_MASK(PULL_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .we(reg_we),
        .addr(reg_addr), .wdata(reg_wdata),
        .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q), .alt_q(alt_q)
    );

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(sync_q)
    );

    gpio_pin_mux #(.WIDTH(WIDTH), .FORCE_MASK(FORCE_MASK),
                   .STROBE_MASK(STROBE_MASK)) u_mux (
        .rst_n(rst_n), .ext_mode_n(ext_mode_n),
        .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q), .alt_q(alt_q),
        .alt_out(alt_out), .alt_oe(alt_oe), .sync_in(sync_q),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .port_view(view)
    );

    assign alt_in = sync_q;

    always_comb begin
        unique case (reg_sel_e'(reg_addr))
            SEL_DATA: reg_rdata = view;
            SEL_DIR:  reg_rdata = dir_q;
            SEL_PULL: reg_rdata = pull_q;
            SEL_ALT:  reg_rdata = alt_q;
            default:  reg_rdata = '0;
        endcase
    end

    assert_forced_alt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode_n |-> ((pad_oe & FORCE_MASK) == (alt_oe & FORCE_MASK)
                         && (pad_out & FORCE_MASK) == (alt_out & FORCE_MASK)));

    assert_alt_override_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & alt_q) == (alt_oe & alt_q)));

    assert_pad_pull_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & ~PULL_MASK) == '0);
endmodule

// File: tb/gpio_port_slice_bench.sv
module gpio_port_slice_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] PULL_M   = 8'h7F;
    localparam logic [7:0] FORCE_M  = 8'h0F;
    localparam logic [7:0] STROBE_M = 8'h30;

    logic clk = 0, rst_n = 0, brk_rst = 0, trap_rst = 0, ext_mode_n = 0;
    logic reg_we = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, alt_out = 0, alt_oe = 0, pad_in = 0;
    logic [7:0] reg_rdata, alt_in, pad_out, pad_oe, pad_pu;

    int checks = 0, failures = 0, cycles = 0;
    string tag = "R1 R7";

    logic [7:0] m_data = 0, m_dir = 0, m_pu = 0, m_alt = 0, m_s1 = 0, m_s2 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_slice u_gpio_port_slice (
        .clk(clk), .rst_n(rst_n), .brk_rst(brk_rst), .trap_rst(trap_rst),
        .ext_mode_n(ext_mode_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alt_out(alt_out),
        .alt_oe(alt_oe), .alt_in(alt_in), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    // Behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_data <= 0; m_dir <= 0; m_pu <= 0; m_alt <= 0; m_s1 <= 0; m_s2 <= 0;
        end else begin
            m_s2 <= m_s1;
            m_s1 <= pad_in;
            if (brk_rst || trap_rst) begin
                m_data <= 0; m_dir <= 0; m_pu <= 0; m_alt <= 0;
            end else if (reg_we) begin
                case (reg_addr)
                    2'd0: m_data <= reg_wdata;
                    2'd1: m_dir  <= reg_wdata;
                    2'd2: m_pu   <= reg_wdata & PULL_M;
                    default: m_alt <= reg_wdata;
                endcase
            end
        end
    end

    task automatic check(string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%02h expected=%02h at cycle %0d",
                     tag, what, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        logic [7:0] eff, oe, outv, pu, outmode, view, rd;
        eff     = m_alt | (ext_mode_n ? 8'h00 : FORCE_M);
        oe      = rst_n ? ((eff & alt_oe) | (~eff & m_dir)) : 8'h00;
        outv    = (eff & alt_out) | (~eff & m_data);
        pu      = m_pu | ((!ext_mode_n && !rst_n) ? STROBE_M : 8'h00);
        outmode = m_dir & ~eff;
        view    = (outmode & m_data) | (~outmode & m_s2);
        case (reg_addr)
            2'd0: rd = view;
            2'd1: rd = m_dir;
            2'd2: rd = m_pu;
            default: rd = m_alt;
        endcase
        check("pad_oe", pad_oe, oe);
        check("pad_out", pad_out, outv);
        check("pad_pu", pad_pu, pu);
        check("alt_in", alt_in, m_s2);
        check("reg_rdata", reg_rdata, rd);
    endtask

    task automatic step(bit rnd_regs);
        @(negedge clk);
        compare_all();
        cycles++;
        if (rnd_regs) begin
            reg_we    = $urandom_range(0, 1);
            reg_addr  = 2'($urandom_range(0, 3));
            reg_wdata = 8'($urandom);
        end
        alt_out = 8'($urandom);
        alt_oe  = 8'($urandom);
        pad_in  = 8'($urandom);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        step(0);
        reg_we = 0;
    endtask

    initial begin
        // R1 / R7: held in reset with the external strap low
        tag = "R1 R7";
        repeat (4) step(0);
        ext_mode_n = 1;
        step(0);
        rst_n = 1;
        // R3 R4 R6 R9 R11: random register traffic, normal mode
        tag = "R3 R4 R6 R9 R11";
        repeat (300) step(1);
        // R5: forced alternate pins
        tag = "R5";
        ext_mode_n = 0;
        repeat (200) step(1);
        ext_mode_n = 1;
        // R2: break and trap resets, one colliding with a write
        tag = "R2";
        wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); wr(2'd3, 8'h0C);
        brk_rst = 1; step(0); brk_rst = 0;
        repeat (3) step(0);
        wr(2'd0, 8'hA5); wr(2'd1, 8'h3C);
        trap_rst = 1; reg_we = 1; reg_addr = 2'd3; reg_wdata = 8'hFF;
        step(0); trap_rst = 0; reg_we = 0;
        repeat (3) step(0);
        // R10: latch written in input and alternate mode, then made output
        tag = "R10";
        wr(2'd3, 8'hF0);
        wr(2'd0, 8'h96);
        wr(2'd3, 8'h00);
        wr(2'd1, 8'hFF);
        reg_addr = 2'd0;
        repeat (3) step(0);
        // R8: synchronizer timing with all pins input
        tag = "R8";
        wr(2'd1, 8'h00);
        repeat (50) step(0);
        // R1 R7: async reset mid-run with strap low
        tag = "R1 R7";
        repeat (20) step(1);
        ext_mode_n = 0;
        rst_n = 0;
        repeat (4) step(0);
        rst_n = 1;
        tag = "R3 R4 R5 R9 R11";
        repeat (100) step(1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule